// File: doc/BRIEF.md
# Control Cell Memory Transaction Processor

This block sits in the cell path of a reconfigurable packet-processing module. Control cells arrive as a fixed-length stream of 32-bit words, with a start-of-cell marker on the first word. The block collects each whole cell and reads the module identifier in its command word. A cell that names another module leaves the block word for word as it came in. Such a cell may be meant for a module further down the chain, or it may be a reply from one further up.

A cell that names this module, and whose trailing CRC is correct, carries a packed batch of memory operations. The batch is run in order against a request/acknowledge memory port. The port can reach two SRAM banks or an SDRAM. The block then emits a response cell. It has the same framing and the same payload slots. Every read slot is filled with the data that came back, and the CRC is recomputed. An addressed cell with a bad CRC is dropped without any side effect. Recovery is left to the controller, which resends it.

Cell layout, as word indices, with CELL_WORDS = 23:
- Word 0: header.
- Word 1: header check.
- Word 2: command word.
- Words 3 to 20: operation slots.
- Word 21: sequence number.
- Word 22: CRC.

Command word fields:
- [31:24]: module ID.
- [23:16]: opcode, echoed only.
- [15:8]: write mask. Bit 8+i set means operation i writes; clear means it reads.
- [7:4]: requested operation count.
- [3]: SRAM bank.
- [1:0]: width mode. 0 selects 32-bit, 1 selects 36-bit, 2 selects 64-bit, and 3 disables all operations.

Top module: `ccmt_top`

## Requirements
- R1: After reset, in_ready is 1 and out_valid and mem_req are 0.
- R2: A cell whose command bits [31:24] differ from MODULE_ID is emitted unchanged, all CELL_WORDS words including its CRC, whether or not that CRC is valid. It causes no memory request.
- R3: Operations of an accepted cell are issued in slot order, one at a time. mem_req and its fields stay stable until mem_ack. After each acknowledge, mem_req is low for at least one cycle.
- R4: The number of operations executed is the minimum of the count field and the mode capacity. The capacity is 8 in 32-bit mode, 6 in 36-bit mode, 4 in 64-bit mode and 0 in mode 3. Operation i starts at word 3 + 2i in 32-bit mode and at word 3 + 3i in the other modes.
- R5: The response repeats words 0, 1, 2, the sequence word and every slot as received. The exception is each read: its word base+1 becomes rdata[31:0], and its word base+2 becomes {28'b0, rdata[35:32]} in 36-bit mode or rdata[63:32] in 64-bit mode.
- R6: The last response word is the CRC-32 of the words before it. The CRC uses polynomial 0x04C11DB7, fed MSB first, seeded with all ones, with no final inversion. An incoming addressed cell is valid only when its last word equals the same CRC over its own preceding words.
- R7: An addressed cell with a wrong CRC produces no memory request and no output word.
- R8: in_ready is 0 from the end of a cell until the last word of its response or forwarded copy has been emitted. out_valid and in_ready are never 1 together.
- R9: A start-of-cell marker always restarts collection at word 0. Words that arrive outside a cell are discarded.
- R10: 64-bit mode targets SDRAM (mem_tgt 2). The other modes target SRAM bank 0 or 1 from command bit 3. Write data is {32'b0, lo} in 32-bit mode, {28'b0, hi[3:0], lo} in 36-bit mode and {hi, lo} in 64-bit mode, where lo is word base+1 and hi is word base+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Input word valid |
| in_sop | input | 1 | Input word is word 0 of a cell |
| in_data | input | 32 | Input cell word |
| in_ready | output | 1 | Block accepts an input word |
| out_valid | output | 1 | Output word valid |
| out_sop | output | 1 | Output word is word 0 of a cell |
| out_data | output | 32 | Output cell word |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_tgt | output | 2 | 0 SRAM bank 0, 1 SRAM bank 1, 2 SDRAM |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 64 | Write data |
| mem_ack | input | 1 | Memory acknowledge, one cycle |
| mem_rdata | input | 64 | Read data, valid with mem_ack |

## Verification
Most faults in this block are visible at the ports within one response cell.
- A wrong slot index or stride shows up at the memory port before any output appears, as a wrong address or write value.
- A wrong operation counter shows up as too many or too few requests.
- A bad patch index corrupts a specific payload word of the response.
- A CRC accumulator that drifts by one word spoils only the final word.
- A faulty ID or CRC decision makes a cell come back when it should not, or never come back.

The bench keeps its own memory image and reference, and compares every request and every output word, so each of these faults is caught at the cell that triggers it.

// File: rtl/ccmt_pkg.sv
package ccmt_pkg;

  localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

  typedef enum logic [1:0] {
    WID_32  = 2'd0,
    WID_36  = 2'd1,
    WID_64  = 2'd2,
    WID_OFF = 2'd3
  } width_e;

  typedef enum logic [1:0] {
    TGT_SRAM0 = 2'd0,
    TGT_SRAM1 = 2'd1,
    TGT_SDRAM = 2'd2
  } target_e;

  // one 32-bit word folded into the running CRC, most significant bit first
  function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [31:0] w);
    logic [31:0] r;
    r = c;
    for (int i = 31; i >= 0; i--) begin
      if (r[31] ^ w[i]) r = {r[30:0], 1'b0} ^ CRC_POLY;
      else              r = {r[30:0], 1'b0};
    end
    return r;
  endfunction

  function automatic logic [3:0] op_capacity(input width_e m);
    case (m)
      WID_32:  return 4'd8;
      WID_36:  return 4'd6;
      WID_64:  return 4'd4;
      default: return 4'd0;
    endcase
  endfunction

  function automatic int op_stride(input width_e m);
    return (m == WID_32) ? 2 : 3;
  endfunction

  function automatic logic [63:0] pack_wdata(input width_e m, input logic [31:0] lo,
                                             input logic [31:0] hi);
    case (m)
      WID_32:  return {32'd0, lo};
      WID_36:  return {28'd0, hi[3:0], lo};
      default: return {hi, lo};
    endcase
  endfunction

endpackage

// File: rtl/ccmt_crc_acc.sv
module ccmt_crc_acc
  import ccmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        restart,
  input  logic        step,
  input  logic [31:0] word,
  output logic [31:0] crc
);
  logic [31:0] base;
  assign base = restart ? CRC_SEED : crc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                crc <= CRC_SEED;
    else if (step)             crc <= crc32_step(base, word);
    else if (restart)          crc <= CRC_SEED;
  end
endmodule

// File: rtl/ccmt_mem_seq.sv
module ccmt_mem_seq #(
  parameter int OPW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [OPW-1:0] n_ops,
  input  logic [31:0]    op_addr,
  input  logic [63:0]    op_wdata,
  input  logic           op_we,
  input  logic [1:0]     op_tgt,
  output logic [OPW-1:0] op_idx,
  output logic           cap_read,
  output logic           done,
  output logic           mem_req,
  output logic           mem_we,
  output logic [1:0]     mem_tgt,
  output logic [31:0]    mem_addr,
  output logic [63:0]    mem_wdata,
  input  logic           mem_ack
);
  typedef enum logic [1:0] {Q_IDLE, Q_ISSUE, Q_GAP, Q_FIN} qstate_e;
  qstate_e        qs;
  logic [OPW-1:0] total;
  logic           acked;

  assign mem_req   = (qs == Q_ISSUE);
  assign mem_we    = mem_req & op_we;
  assign mem_tgt   = op_tgt;
  assign mem_addr  = op_addr;
  assign mem_wdata = op_wdata;
  assign acked     = mem_req & mem_ack;
  assign cap_read  = acked & ~op_we;
  assign done      = (qs == Q_FIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qs     <= Q_IDLE;
      total  <= '0;
      op_idx <= '0;
    end else begin
      case (qs)
        Q_IDLE: if (start) begin
          total  <= n_ops;
          op_idx <= '0;
          qs     <= (n_ops == '0) ? Q_FIN : Q_ISSUE;
        end
        Q_ISSUE: if (acked) begin
          op_idx <= op_idx + 1'b1;
          qs     <= (op_idx + 1'b1 == total) ? Q_FIN : Q_GAP;
        end
        Q_GAP:   qs <= Q_ISSUE;
        default: qs <= Q_IDLE;
      endcase
    end
  end

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) &&
                            $stable(mem_wdata) && $stable(mem_tgt));
  // R3
  req_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack |=> !mem_req);
endmodule

// File: rtl/ccmt_top.sv
module ccmt_top
  import ccmt_pkg::*;
#(
  parameter logic [7:0] MODULE_ID  = 8'h2A,
  parameter int         CELL_WORDS = 23
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        in_sop,
  input  logic [31:0] in_data,
  output logic        in_ready,
  output logic        out_valid,
  output logic        out_sop,
  output logic [31:0] out_data,
  output logic        mem_req,
  output logic        mem_we,
  output logic [1:0]  mem_tgt,
  output logic [31:0] mem_addr,
  output logic [63:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [63:0] mem_rdata
);
  localparam int LAST = CELL_WORDS - 1;
  localparam int CMD  = 2;
  localparam int PAY0 = 3;
  localparam int IDXW = $clog2(CELL_WORDS);
  localparam int OPW  = 4;

  typedef enum logic [1:0] {S_RECV, S_DECIDE, S_MEM, S_EMIT} state_e;
  state_e         st;
  logic [31:0]    cbuf [CELL_WORDS];
  logic [IDXW-1:0] rx_idx, tx_idx;
  logic           rx_active, fwd;
  logic [31:0]    rx_crc, tx_crc;

  // named events used by the assertions
  logic accept, cell_end, id_hit, crc_ok, seq_start, bad_drop, fwd_start;

  width_e         mode;
  logic [3:0]     cap, req_cnt;
  logic [OPW-1:0] n_ops, op_idx;
  logic           cap_read, seq_done;
  int             base;
  logic [31:0]    op_addr, op_lo, op_hi;
  logic           op_we;
  logic [1:0]     op_tgt;

  assign in_ready  = (st == S_RECV);
  assign accept    = in_valid & in_ready;
  assign cell_end  = accept & ~in_sop & rx_active & (rx_idx == IDXW'(LAST));
  assign id_hit    = (cbuf[CMD][31:24] == MODULE_ID);
  assign crc_ok    = (cbuf[LAST] == rx_crc);
  assign seq_start = (st == S_DECIDE) & id_hit & crc_ok;
  assign bad_drop  = (st == S_DECIDE) & id_hit & ~crc_ok;
  assign fwd_start = (st == S_DECIDE) & ~id_hit;

  // operation decode from the stored command word
  assign mode    = width_e'(cbuf[CMD][1:0]);
  assign cap     = op_capacity(mode);
  assign req_cnt = cbuf[CMD][7:4];
  assign n_ops   = (req_cnt < cap) ? req_cnt : cap;
  assign base    = PAY0 + int'(op_idx) * op_stride(mode);

  always_comb begin
    op_addr = '0;
    op_lo   = '0;
    op_hi   = '0;
    if (base + 2 < CELL_WORDS) begin
      op_addr = cbuf[base];
      op_lo   = cbuf[base+1];
      op_hi   = cbuf[base+2];
    end
  end
  assign op_we  = cbuf[CMD][8 + int'(op_idx[2:0])];
  assign op_tgt = (mode == WID_64) ? TGT_SDRAM : (cbuf[CMD][3] ? TGT_SRAM1 : TGT_SRAM0);

  ccmt_mem_seq #(.OPW(OPW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(seq_start), .n_ops(n_ops),
    .op_addr(op_addr), .op_wdata(pack_wdata(mode, op_lo, op_hi)),
    .op_we(op_we), .op_tgt(op_tgt), .op_idx(op_idx), .cap_read(cap_read),
    .done(seq_done), .mem_req(mem_req), .mem_we(mem_we), .mem_tgt(mem_tgt),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack)
  );

  // running CRC over received words 0..LAST-1
  ccmt_crc_acc u_rx_crc (
    .clk(clk), .rst_n(rst_n), .restart(accept & in_sop),
    .step(accept & (in_sop | (rx_active & (rx_idx != IDXW'(LAST))))),
    .word(in_data), .crc(rx_crc)
  );

  // running CRC over emitted words 0..LAST-1
  ccmt_crc_acc u_tx_crc (
    .clk(clk), .rst_n(rst_n), .restart((st == S_EMIT) & (tx_idx == '0)),
    .step((st == S_EMIT) & (tx_idx != IDXW'(LAST))),
    .word(cbuf[tx_idx]), .crc(tx_crc)
  );

  assign out_valid = (st == S_EMIT);
  assign out_sop   = out_valid & (tx_idx == '0);
  assign out_data  = !out_valid ? '0 :
                     ((tx_idx == IDXW'(LAST)) && !fwd) ? tx_crc : cbuf[tx_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_RECV;
      rx_idx    <= '0;
      tx_idx    <= '0;
      rx_active <= 1'b0;
      fwd       <= 1'b0;
      for (int i = 0; i < CELL_WORDS; i++) cbuf[i] <= '0;
    end else begin
      case (st)
        S_RECV: if (accept) begin
          if (in_sop) begin
            cbuf[0]   <= in_data;
            rx_idx    <= IDXW'(1);
            rx_active <= 1'b1;
          end else if (rx_active) begin
            cbuf[rx_idx] <= in_data;
            if (rx_idx == IDXW'(LAST)) begin
              rx_active <= 1'b0;
              st        <= S_DECIDE;
            end else begin
              rx_idx <= rx_idx + 1'b1;
            end
          end
        end
        S_DECIDE: begin
          tx_idx <= '0;
          fwd    <= ~id_hit;
          if (!id_hit)     st <= S_EMIT;
          else if (crc_ok) st <= S_MEM;
          else             st <= S_RECV;
        end
        S_MEM: begin
          if (cap_read && (base + 2 < CELL_WORDS)) begin
            cbuf[base+1] <= mem_rdata[31:0];
            if (mode == WID_36)      cbuf[base+2] <= {28'd0, mem_rdata[35:32]};
            else if (mode == WID_64) cbuf[base+2] <= mem_rdata[63:32];
          end
          if (seq_done) st <= S_EMIT;
        end
        default: begin
          if (tx_idx == IDXW'(LAST)) st <= S_RECV;
          else tx_idx <= tx_idx + 1'b1;
        end
      endcase
    end
  end

  // R8
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
  // R8
  hold_after_cell_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cell_end |=> !in_ready);
  // R7
  bad_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_drop |=> !mem_req && !out_valid);
  // R2
  fwd_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_start |=> !mem_req && out_sop);
  // R3
  req_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !in_ready && !out_valid);
endmodule

// File: tb/ccmt_top_test.sv
module ccmt_top_test;
  localparam int         CW  = 23;
  localparam logic [7:0] MID = 8'h2A;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        in_valid = 1'b0, in_sop = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready, out_valid, out_sop;
  logic [31:0] out_data;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [1:0]  mem_tgt;
  logic [31:0] mem_addr;
  logic [63:0] mem_wdata, mem_rdata = '0;

  ccmt_top #(.MODULE_ID(MID), .CELL_WORDS(CW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_sop(out_sop), .out_data(out_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_tgt(mem_tgt), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  always #2 clk = ~clk;

  int tests = 0, fails = 0, overlap_err = 0;
  logic [31:0] cell_in [CW];
  logic [31:0] exp_out [CW];
  logic [31:0] got_words [$];
  logic [98:0] got_req [$];
  logic [98:0] exp_req [$];
  logic [63:0] dut_mem [logic [33:0]];
  logic [63:0] ref_mem [logic [33:0]];
  int wait_left = -1;

  function automatic logic [63:0] dflt(input logic [1:0] t, input logic [31:0] a);
    return {a ^ 32'h5A5A_0000, ~a ^ {30'd0, t}};
  endfunction

  // bench CRC: bit stream view, polynomial 0x04C11DB7, seed all ones, no final inversion
  function automatic logic [31:0] bcrc(input int n);
    logic [31:0] c = 32'hFFFF_FFFF;
    logic fb;
    for (int k = 0; k < n; k++)
      for (int b = 31; b >= 0; b--) begin
        fb = c[31] ^ exp_out[k][b];
        c  = {c[30:0], 1'b0};
        if (fb) c = c ^ 32'h04C1_1DB7;
      end
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory responder
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      wait_left = -1;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
    end else if (mem_req) begin
      if (wait_left < 0) wait_left = int'($urandom % 4);
      if (wait_left == 0) begin
        got_req.push_back({mem_tgt, mem_we, mem_addr, mem_wdata});
        if (mem_we) dut_mem[{mem_tgt, mem_addr}] = mem_wdata;
        mem_rdata <= dut_mem.exists({mem_tgt, mem_addr}) ? dut_mem[{mem_tgt, mem_addr}]
                                                        : dflt(mem_tgt, mem_addr);
        mem_ack <= 1'b1;
        wait_left = -1;
      end else wait_left--;
    end
  end

  // output monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) got_words.push_back(out_data);
      if (out_valid && in_ready) overlap_err++;
    end
  end

  // builds exp_out / exp_req from cell_in; returns 0 fwd, 1 processed, 2 dropped
  function automatic int build_expected();
    logic [31:0] cmd;
    int cap, n, stride, b;
    logic [1:0] t;
    logic [63:0] wd, rd;
    logic [33:0] key;
    for (int k = 0; k < CW; k++) exp_out[k] = cell_in[k];
    exp_req.delete();
    cmd = cell_in[2];
    if (cmd[31:24] != MID) return 0;
    if (bcrc(CW - 1) != cell_in[CW-1]) return 2;
    cap = (cmd[1:0] == 0) ? 8 : (cmd[1:0] == 1) ? 6 : (cmd[1:0] == 2) ? 4 : 0;
    n = (int'(cmd[7:4]) < cap) ? int'(cmd[7:4]) : cap;
    stride = (cmd[1:0] == 0) ? 2 : 3;
    for (int i = 0; i < n; i++) begin
      b = 3 + i * stride;
      t = (cmd[1:0] == 2) ? 2'd2 : {1'b0, cmd[3]};
      case (cmd[1:0])
        2'd0:    wd = {32'd0, cell_in[b+1]};
        2'd1:    wd = {28'd0, cell_in[b+2][3:0], cell_in[b+1]};
        default: wd = {cell_in[b+2], cell_in[b+1]};
      endcase
      key = {t, cell_in[b]};
      exp_req.push_back({t, cmd[8+i], cell_in[b], wd});
      if (cmd[8+i]) ref_mem[key] = wd;
      else begin
        rd = ref_mem.exists(key) ? ref_mem[key] : dflt(t, cell_in[b]);
        exp_out[b+1] = rd[31:0];
        if (cmd[1:0] == 1) exp_out[b+2] = {28'd0, rd[35:32]};
        if (cmd[1:0] == 2) exp_out[b+2] = rd[63:32];
      end
    end
    exp_out[CW-1] = bcrc(CW - 1);
    return 1;
  endfunction

  task automatic make_cell(input logic [7:0] id, input logic [1:0] mode, input logic [3:0] cnt,
                           input logic [7:0] wmask, input bit bank, input bit good_crc);
    cell_in[0] = 32'h0000_0340 | ($urandom & 32'h0FF0_0000);
    cell_in[1] = $urandom;
    cell_in[2] = {id, 8'($urandom), wmask, cnt, bank, 1'b0, mode};
    for (int k = 3; k < CW - 2; k++)
      cell_in[k] = (k % 3 == 0) ? ($urandom & 32'hF) : $urandom;
    cell_in[CW-2] = $urandom;
    for (int k = 0; k < CW; k++) exp_out[k] = cell_in[k];
    cell_in[CW-1] = bcrc(CW - 1) ^ (good_crc ? 32'd0 : 32'h0000_0100);
  endtask

  task automatic send_word(input bit sop, input logic [31:0] d);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_sop = sop; in_data = d;
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0;
  endtask

  task automatic send_cell();
    for (int k = 0; k < CW; k++) begin
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1; in_sop = (k == 0); in_data = cell_in[k];
    end
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0;
  endtask

  task automatic run_cell(input string tag);
    int kind, w0, mism;
    kind = build_expected();
    w0 = got_words.size();
    got_req.delete();
    send_cell();
    if (kind == 2) begin
      repeat (80) @(negedge clk);
      check(got_words.size() == w0, "R7", {tag, " dropped cell output words"},
            64'(got_words.size() - w0), 64'd0);
      check(got_req.size() == 0, "R7", {tag, " dropped cell memory requests"},
            64'(got_req.size()), 64'd0);
      return;
    end
    for (int t = 0; t < 800 && got_words.size() < w0 + CW; t++) @(negedge clk);
    mism = -1;
    for (int k = 0; k < CW - 1; k++)
      if (mism < 0 && (w0 + k >= got_words.size() || got_words[w0+k] !== exp_out[k])) mism = k;
    if (mism < 0) check(1'b1, kind == 0 ? "R2" : "R5", tag, 0, 0);
    else check(1'b0, kind == 0 ? "R2" : "R5", $sformatf("%s word %0d", tag, mism),
               (w0 + mism < got_words.size()) ? 64'(got_words[w0+mism]) : 64'hX, 64'(exp_out[mism]));
    check(got_words.size() >= w0 + CW && got_words[w0+CW-1] === exp_out[CW-1],
          kind == 0 ? "R2" : "R6", {tag, " last word"},
          (got_words.size() >= w0 + CW) ? 64'(got_words[w0+CW-1]) : 64'hX, 64'(exp_out[CW-1]));
    mism = (got_req.size() != exp_req.size()) ? 0 : -1;
    for (int i = 0; i < exp_req.size() && mism < 0; i++)
      if (got_req[i] !== exp_req[i]) mism = i + 1;
    check(mism < 0, (kind == 0) ? "R2" : "R3", {tag, " memory request list (R4 R10)"},
          64'(got_req.size()), 64'(exp_req.size()));
  endtask

  initial begin
    #(4 * 190000);
    fails++; tests++;
    $display("FAIL watchdog: run did not complete");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(in_ready === 1'b1, "R1", "in_ready in reset", 64'(in_ready), 64'd1);
    check(out_valid === 1'b0, "R1", "out_valid in reset", 64'(out_valid), 64'd0);
    check(mem_req === 1'b0, "R1", "mem_req in reset", 64'(mem_req), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 foreign module ID, even with a bad CRC
    make_cell(8'h11, 2'd0, 4'd5, 8'h0F, 1'b0, 1'b0); run_cell("foreign id");
    // R4 count above capacity in each mode
    make_cell(MID, 2'd0, 4'd15, 8'hA5, 1'b0, 1'b1); run_cell("32-bit full");
    make_cell(MID, 2'd1, 4'd15, 8'h3C, 1'b1, 1'b1); run_cell("36-bit full bank1");
    make_cell(MID, 2'd2, 4'd9, 8'h05, 1'b0, 1'b1);  run_cell("64-bit full");
    make_cell(MID, 2'd3, 4'd7, 8'hFF, 1'b0, 1'b1);  run_cell("mode off");
    make_cell(MID, 2'd0, 4'd0, 8'hFF, 1'b0, 1'b1);  run_cell("zero count");
    // R3 write then read back the same address in one cell
    make_cell(MID, 2'd2, 4'd2, 8'h01, 1'b0, 1'b1);
    cell_in[6] = cell_in[3];
    for (int k = 0; k < CW; k++) exp_out[k] = cell_in[k];
    cell_in[CW-1] = bcrc(CW - 1);
    run_cell("64-bit write then read");
    // R7 bad CRC on an addressed cell
    make_cell(MID, 2'd0, 4'd4, 8'h0F, 1'b0, 1'b0); run_cell("bad crc");
    // R9 stray words, then an aborted cell restarted by a new marker
    send_word(1'b0, 32'hDEAD_0001);
    send_word(1'b0, 32'hDEAD_0002);
    send_word(1'b1, {MID, 24'h0});
    for (int k = 0; k < 5; k++) send_word(1'b0, 32'hBAD0_0000 + 32'(k));
    make_cell(MID, 2'd1, 4'd3, 8'h02, 1'b0, 1'b1); run_cell("R9 restart");

    for (int r = 0; r < 40; r++) begin
      logic [7:0] id;
      id = ($urandom % 5 == 0) ? 8'($urandom) : MID;
      make_cell(id, 2'($urandom), 4'($urandom), 8'($urandom), 1'($urandom),
                ($urandom % 8) != 0);
      run_cell($sformatf("random %0d", r));
    end

    check(overlap_err == 0, "R8", "out_valid with in_ready", 64'(overlap_err), 64'd0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule